// File: doc/BRIEF.md
# Pipelined Flash Command Sequencer

This block takes memory-controller commands over a small register-write port and runs them one after another against a behavioural model of a nonvolatile array. A command has three parts: an opcode, an address word and a data word. Software stages the three parts and then writes a launch bit. A launched command goes into a front slot. From there an executor pulls it as soon as the executor is free. Software can therefore queue a second complete command while the first is still running.

All program and erase timing is counted in ticks of a slow timebase. A software-written divider derives that timebase from the input clock. Before a program or erase pulse starts, the executor raises an abstract high-voltage enable and holds it for a ramp interval. Two programs to the same row that are queued back to back share one high-voltage period, so the enable does not ramp down and up again between them. Erase verify scans a row for all-ones words. Compress folds a row into a checksum. Abort stops an erase that is running.

Status flags report when the front slot is free and when all queued work has finished. Each flag has its own interrupt output, gated by its own enable bit. Illegal requests set a sticky access-error flag, which refuses further launches until software clears it.

Top module: `flash_cmd_seq`

## Requirements
- R1: Writing the divider register (select 0, value in wdata[7:0]) with value D makes one timebase tick every D+1 clocks. A launch made before the first divider write is refused and sets the access-error flag. A program strobe lasts exactly PROG_TICKS*(D+1) clocks and an erase strobe lasts exactly ERASE_TICKS*(D+1) clocks.
- R2: The staging selects are address (select 1), data (select 2) and opcode (select 3, wdata[2:0]). A write to select 4 with wdata[0]=1 is a launch. A launch is accepted when the front slot is empty, the error flag is clear, the divider has been written and the opcode is legal. An accepted launch fills the front slot, and buf_empty reads 0 while the slot is occupied.
- R3: A launch made while the front slot is occupied is discarded and sets the access-error flag.
- R4: The legal opcodes are 1 program, 2 erase, 3 verify, 4 abort and 5 compress. A launch with opcode 0, 6 or 7 sets the access-error flag. While the flag is set, launches are ignored and nothing is queued. A select-4 write with wdata[1]=1 clears the flag.
- R5: A program first raises hv_en for RAMP_TICKS ticks and then raises pgm_strobe. At the end of the strobe, the array word at the address becomes its old value ANDed with the data.
- R6: When a program ends and the front slot holds a program to the same row (address bits above the low ROW_BITS), hv_en stays high and the second program starts with no ramp. If the row differs, hv_en falls and then ramps again.
- R7: An erase raises ers_strobe after the ramp. At the end of the strobe, every word of the addressed row is set to all ones.
- R8: An abort that sits in the front slot while an erase is ramping or pulsing ends that erase on the next clock. hv_en drops and the array is left unchanged. An abort with no erase running completes with no effect.
- R9: Verify reads every word of the addressed row. It sets blank to 1 only if all of them are all ones, and to 0 otherwise.
- R10: Compress starts from 0 and, for each word of the row in ascending address order, rotates the value left by one bit and XORs in the word. The final value appears on result.
- R11: cmd_done is 1 exactly when the front slot is empty and the executor is idle.
- R12: A write to select 5 sets the interrupt enables: wdata[0] for buffer-empty and wdata[1] for done. irq_empty equals buf_empty AND its enable, and irq_done equals cmd_done AND its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DW | Register write data |
| buf_empty | output | 1 | Front slot can take a command |
| cmd_done | output | 1 | Nothing queued or running |
| acc_err | output | 1 | Sticky access-error flag |
| blank | output | 1 | Result of the last verify |
| result | output | DW | Checksum from the last compress |
| hv_en | output | 1 | High-voltage enable |
| pgm_strobe | output | 1 | Program operation strobe |
| ers_strobe | output | 1 | Erase operation strobe |
| irq_empty | output | 1 | Buffer-empty interrupt |
| irq_done | output | 1 | Command-complete interrupt |

## Verification
The assertions assume that software writes the divider only while cmd_done is high, because a divider change in the middle of a command would move tick boundaries that the strobe-ordering properties rely on. They also assume register writes are single-cycle pulses. The stimulus keeps to both assumptions: every divider write happens after the bench has waited for cmd_done, and every register access lasts exactly one clock. Aborts are issued only once an erase strobe has been seen or the block is idle, so both abort cases are covered.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_PROG     = 3'd1,
        OP_ERASE    = 3'd2,
        OP_VERIFY   = 3'd3,
        OP_ABORT    = 3'd4,
        OP_COMPRESS = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } fcs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RAMP = 2'd1,
        ST_RUN  = 2'd2,
        ST_SCAN = 2'd3
    } fcs_state_e;

    localparam logic [2:0] SEL_DIV  = 3'd0;
    localparam logic [2:0] SEL_ADDR = 3'd1;
    localparam logic [2:0] SEL_DATA = 3'd2;
    localparam logic [2:0] SEL_CMD  = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;
    localparam logic [2:0] SEL_IE   = 3'd5;

    function automatic logic op_legal(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fcs_prescaler.sv
module fcs_prescaler #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            div_we,
    input  logic [DIVW-1:0] div_val,
    output logic            div_ok,
    output logic            tick
);
    logic [DIVW-1:0] div_q;
    logic [DIVW-1:0] pc;

    assign tick = div_ok && (pc == div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            div_ok <= 1'b0;
            pc     <= '0;
        end else if (div_we) begin
            div_q  <= div_val;
            div_ok <= 1'b1;
            pc     <= '0;
        end else if (div_ok) begin
            pc <= tick ? '0 : pc + 1'b1;
        end
    end

    // R1: with a divider above zero, two ticks never come on adjacent clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && (div_q != '0) && !div_we) |=> !tick);

endmodule

// File: rtl/fcs_cmd_queue.sv
module fcs_cmd_queue import fcs_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 16,
    localparam int CW = 3 + AW + DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    input  logic          div_ok,
    input  logic          take,
    output logic          front_valid,
    output logic [CW-1:0] front_cmd,
    output logic          acc_err
);
    logic [2:0]    stg_op;
    logic [AW-1:0] stg_addr;
    logic [DW-1:0] stg_data;
    logic          launch, clr, accept, refuse;

    assign launch = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[0];
    assign clr    = reg_we && (reg_sel == SEL_CTRL) && reg_wdata[1];
    assign accept = launch && !acc_err && !front_valid && div_ok && op_legal(stg_op);
    assign refuse = launch && !acc_err && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_op      <= '0;
            stg_addr    <= '0;
            stg_data    <= '0;
            front_valid <= 1'b0;
            front_cmd   <= '0;
            acc_err     <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_ADDR) stg_addr <= reg_wdata[AW-1:0];
            if (reg_we && reg_sel == SEL_DATA) stg_data <= reg_wdata;
            if (reg_we && reg_sel == SEL_CMD)  stg_op   <= reg_wdata[2:0];
            if (refuse)   acc_err <= 1'b1;
            else if (clr) acc_err <= 1'b0;
            if (accept) begin
                front_valid <= 1'b1;
                front_cmd   <= {stg_op, stg_addr, stg_data};
            end else if (take) begin
                front_valid <= 1'b0;
            end
        end
    end

    // R1: the front slot only fills once the divider has been written
    p_fill_needs_div_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(front_valid) |-> $past(div_ok));
    // R3: a launch against an occupied slot raises the error flag
    p_full_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (launch && front_valid && !acc_err) |=> acc_err);
    // R4: the error flag holds until it is cleared
    p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_err && !clr) |=> acc_err);

endmodule

// File: rtl/fcs_array_stub.sv
module fcs_array_stub #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int ROW_BITS = 3,
    localparam int DEPTH = 1 << AW,
    localparam int ROWW = 1 << ROW_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          commit_prog,
    input  logic          commit_erase,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] cells [DEPTH];

    assign rd_data = cells[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
        end else if (commit_prog) begin
            cells[commit_addr] <= cells[commit_addr] & commit_data;
        end else if (commit_erase) begin
            for (int i = 0; i < ROWW; i++)
                cells[{commit_addr[AW-1:ROW_BITS], ROW_BITS'(i)}] <= '1;
        end
    end

    // R5: the stub is never asked to program and erase at once
    p_one_commit_r5: assert property (@(posedge clk) disable iff (rst)
        !(commit_prog && commit_erase));

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine import fcs_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int ROW_BITS = 3,
    parameter int RAMP_TICKS = 2,
    parameter int PROG_TICKS = 3,
    parameter int ERASE_TICKS = 6,
    localparam int CW = 3 + AW + DW,
    localparam int ROWW = 1 << ROW_BITS,
    localparam int CNTW = $clog2(max3(RAMP_TICKS, PROG_TICKS, ERASE_TICKS) + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          front_valid,
    input  logic [CW-1:0] front_cmd,
    input  logic [DW-1:0] rd_data,
    output logic          take,
    output logic [AW-1:0] rd_addr,
    output logic          commit_prog,
    output logic          commit_erase,
    output logic [AW-1:0] commit_addr,
    output logic [DW-1:0] commit_data,
    output logic          idle,
    output logic          hv_en,
    output logic          pgm_strobe,
    output logic          ers_strobe,
    output logic          blank,
    output logic [DW-1:0] result
);
    typedef struct packed {
        fcs_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } cmd_t;

    cmd_t            fcmd, ecmd;
    fcs_state_e      st;
    logic [CNTW-1:0] cnt, dur;
    logic [ROW_BITS-1:0] idx;
    logic [DW-1:0]   cks, fold;
    logic            blk, is_erase, last_tick, abort_hit, chain, word_ones;

    assign fcmd      = cmd_t'(front_cmd);
    assign is_erase  = (ecmd.op == OP_ERASE);
    assign dur       = is_erase ? CNTW'(ERASE_TICKS) : CNTW'(PROG_TICKS);
    assign last_tick = (st == ST_RUN) && tick && (cnt == dur - 1'b1);
    assign abort_hit = ((st == ST_RAMP) || (st == ST_RUN)) && is_erase
                       && front_valid && (fcmd.op == OP_ABORT);
    assign chain     = last_tick && (ecmd.op == OP_PROG) && front_valid
                       && (fcmd.op == OP_PROG)
                       && (fcmd.addr[AW-1:ROW_BITS] == ecmd.addr[AW-1:ROW_BITS]);

    assign take         = ((st == ST_IDLE) && front_valid) || chain || abort_hit;
    assign commit_prog  = last_tick && (ecmd.op == OP_PROG);
    assign commit_erase = last_tick && is_erase && !abort_hit;
    assign commit_addr  = ecmd.addr;
    assign commit_data  = ecmd.data;
    assign rd_addr      = {ecmd.addr[AW-1:ROW_BITS], idx};
    assign word_ones    = (rd_data == {DW{1'b1}});
    assign fold         = {cks[DW-2:0], cks[DW-1]} ^ rd_data;

    assign idle       = (st == ST_IDLE);
    assign hv_en      = (st == ST_RAMP) || (st == ST_RUN);
    assign pgm_strobe = (st == ST_RUN) && (ecmd.op == OP_PROG);
    assign ers_strobe = (st == ST_RUN) && is_erase;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ecmd   <= '0;
            cnt    <= '0;
            idx    <= '0;
            cks    <= '0;
            blk    <= 1'b0;
            blank  <= 1'b0;
            result <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (front_valid) begin
                    ecmd <= fcmd;
                    cnt  <= '0;
                    idx  <= '0;
                    cks  <= '0;
                    blk  <= 1'b1;
                    case (fcmd.op)
                        OP_PROG, OP_ERASE:      st <= ST_RAMP;
                        OP_VERIFY, OP_COMPRESS: st <= ST_SCAN;
                        default:                st <= ST_IDLE;
                    endcase
                end
                ST_RAMP: begin
                    if (abort_hit) st <= ST_IDLE;
                    else if (tick) begin
                        if (cnt == CNTW'(RAMP_TICKS - 1)) begin
                            st  <= ST_RUN;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (abort_hit) st <= ST_IDLE;
                    else if (last_tick) begin
                        if (chain) begin
                            ecmd <= fcmd;
                            cnt  <= '0;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SCAN: begin
                    cks <= fold;
                    blk <= blk && word_ones;
                    if (idx == ROW_BITS'(ROWW - 1)) begin
                        st <= ST_IDLE;
                        if (ecmd.op == OP_VERIFY) blank  <= blk && word_ones;
                        else                      result <= fold;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            endcase
        end
    end

    // R5: the two operation strobes never overlap
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(pgm_strobe && ers_strobe));
    // R5: a strobe is only active under high voltage
    p_strobe_needs_hv_r5: assert property (@(posedge clk) disable iff (rst)
        (pgm_strobe || ers_strobe) |-> hv_en);
    // R5: high voltage starts with a ramp, never directly with a strobe
    p_ramp_first_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(hv_en) |-> (!pgm_strobe && !ers_strobe));
    // R6: a same-row chain keeps high voltage and the program strobe on
    p_chain_keeps_hv_r6: assert property (@(posedge clk) disable iff (rst)
        chain |=> (hv_en && pgm_strobe));
    // R8: an abort against a running erase drops high voltage next clock
    p_abort_drops_hv_r8: assert property (@(posedge clk) disable iff (rst)
        abort_hit |=> !hv_en);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq import fcs_pkg::*; #(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int ROW_BITS = 3,
    parameter int DIVW = 8,
    parameter int RAMP_TICKS = 2,
    parameter int PROG_TICKS = 3,
    parameter int ERASE_TICKS = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic          buf_empty,
    output logic          cmd_done,
    output logic          acc_err,
    output logic          blank,
    output logic [DW-1:0] result,
    output logic          hv_en,
    output logic          pgm_strobe,
    output logic          ers_strobe,
    output logic          irq_empty,
    output logic          irq_done
);
    localparam int CW = 3 + AW + DW;

    logic          div_ok, tick, front_valid, take, eng_idle;
    logic [CW-1:0] front_cmd;
    logic [AW-1:0] rd_addr, commit_addr;
    logic [DW-1:0] rd_data, commit_data;
    logic          commit_prog, commit_erase;
    logic          ie_empty, ie_done;

    fcs_prescaler #(.DIVW(DIVW)) u_pre (
        .clk(clk), .rst(rst),
        .div_we(reg_we && reg_sel == SEL_DIV),
        .div_val(reg_wdata[DIVW-1:0]),
        .div_ok(div_ok), .tick(tick)
    );

    fcs_cmd_queue #(.AW(AW), .DW(DW)) u_q (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .div_ok(div_ok), .take(take),
        .front_valid(front_valid), .front_cmd(front_cmd), .acc_err(acc_err)
    );

    fcs_engine #(
        .AW(AW), .DW(DW), .ROW_BITS(ROW_BITS),
        .RAMP_TICKS(RAMP_TICKS), .PROG_TICKS(PROG_TICKS), .ERASE_TICKS(ERASE_TICKS)
    ) u_eng (
        .clk(clk), .rst(rst), .tick(tick),
        .front_valid(front_valid), .front_cmd(front_cmd), .rd_data(rd_data),
        .take(take), .rd_addr(rd_addr),
        .commit_prog(commit_prog), .commit_erase(commit_erase),
        .commit_addr(commit_addr), .commit_data(commit_data),
        .idle(eng_idle), .hv_en(hv_en),
        .pgm_strobe(pgm_strobe), .ers_strobe(ers_strobe),
        .blank(blank), .result(result)
    );

    fcs_array_stub #(.AW(AW), .DW(DW), .ROW_BITS(ROW_BITS)) u_arr (
        .clk(clk), .rst(rst),
        .commit_prog(commit_prog), .commit_erase(commit_erase),
        .commit_addr(commit_addr), .commit_data(commit_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_empty <= 1'b0;
            ie_done  <= 1'b0;
        end else if (reg_we && reg_sel == SEL_IE) begin
            ie_empty <= reg_wdata[0];
            ie_done  <= reg_wdata[1];
        end
    end

    assign buf_empty = !front_valid;
    assign cmd_done  = !front_valid && eng_idle;
    assign irq_empty = buf_empty && ie_empty;
    assign irq_done  = cmd_done && ie_done;

    // R12: an interrupt never fires without its flag
    p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
        (irq_empty |-> buf_empty) and (irq_done |-> cmd_done));
    // R11: completion implies an empty slot and no high voltage
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        cmd_done |-> (buf_empty && !hv_en && !pgm_strobe && !ers_strobe));

endmodule

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int RAMP = 2, PROG = 3, ERASE = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        buf_empty, cmd_done, acc_err, blank, hv_en, pgm_strobe, ers_strobe;
    logic        irq_empty, irq_done;
    logic [15:0] result;

    int checks = 0, fails = 0, cycles = 0;
    bit armed = 1'b0, finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .buf_empty(buf_empty), .cmd_done(cmd_done), .acc_err(acc_err), .blank(blank),
        .result(result), .hv_en(hv_en), .pgm_strobe(pgm_strobe), .ers_strobe(ers_strobe),
        .irq_empty(irq_empty), .irq_done(irq_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_mem [64];
    bit m_divset, m_fv, m_err, m_blank, m_blk, m_iee, m_ied;
    int m_div, m_pc, m_st, m_cnt, m_idx;
    int m_fop, m_fad, m_sop, m_sad, e_op, e_ad;
    logic [15:0] m_fdt, m_sdt, e_dt, m_cks, m_result;

    always @(posedge clk) begin
        bit tk, launch, clr, take, abort, accept, refuse, old_fv;
        int dur;
        logic [15:0] w, nc;
        if (rst) begin
            for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF;
            m_divset = 0; m_fv = 0; m_err = 0; m_blank = 0; m_blk = 0; m_iee = 0; m_ied = 0;
            m_div = 0; m_pc = 0; m_st = 0; m_cnt = 0; m_idx = 0;
            m_fop = 0; m_fad = 0; m_sop = 0; m_sad = 0; e_op = 0; e_ad = 0;
            m_fdt = 0; m_sdt = 0; e_dt = 0; m_cks = 0; m_result = 0;
        end else begin
            tk = m_divset && (m_pc == m_div);
            launch = reg_we && reg_sel == 4 && reg_wdata[0];
            clr    = reg_we && reg_sel == 4 && reg_wdata[1];
            old_fv = m_fv;
            take = 0;
            dur = (e_op == 2) ? ERASE : PROG;
            abort = (m_st == 1 || m_st == 2) && e_op == 2 && m_fv && m_fop == 4;
            case (m_st)
                0: if (m_fv) begin
                    take = 1; e_op = m_fop; e_ad = m_fad; e_dt = m_fdt;
                    m_cnt = 0; m_idx = 0; m_cks = 0; m_blk = 1;
                    if (m_fop == 1 || m_fop == 2) m_st = 1;
                    else if (m_fop == 3 || m_fop == 5) m_st = 3;
                end
                1: if (abort) begin take = 1; m_st = 0; end
                   else if (tk) begin
                       if (m_cnt == RAMP - 1) begin m_st = 2; m_cnt = 0; end
                       else m_cnt++;
                   end
                2: if (abort) begin take = 1; m_st = 0; end
                   else if (tk && m_cnt == dur - 1) begin
                       if (e_op == 1) m_mem[e_ad] = m_mem[e_ad] & e_dt;
                       else for (int i = 0; i < 8; i++) m_mem[(e_ad / 8) * 8 + i] = 16'hFFFF;
                       if (e_op == 1 && m_fv && m_fop == 1 && (m_fad / 8) == (e_ad / 8)) begin
                           take = 1; e_op = m_fop; e_ad = m_fad; e_dt = m_fdt; m_cnt = 0;
                       end else m_st = 0;
                   end else if (tk) m_cnt++;
                default: begin
                    w = m_mem[(e_ad / 8) * 8 + m_idx];
                    nc = {m_cks[14:0], m_cks[15]} ^ w;
                    if (m_idx == 7) begin
                        m_st = 0;
                        if (e_op == 3) m_blank = m_blk && (w == 16'hFFFF);
                        else m_result = nc;
                    end else m_idx++;
                    m_cks = nc;
                    m_blk = m_blk && (w == 16'hFFFF);
                end
            endcase
            accept = launch && !m_err && !old_fv && m_divset && m_sop >= 1 && m_sop <= 5;
            refuse = launch && !m_err && !accept;
            if (refuse) m_err = 1; else if (clr) m_err = 0;
            if (accept) begin m_fv = 1; m_fop = m_sop; m_fad = m_sad; m_fdt = m_sdt; end
            else if (take) m_fv = 0;
            if (reg_we && reg_sel == 1) m_sad = int'(reg_wdata[5:0]);
            if (reg_we && reg_sel == 2) m_sdt = reg_wdata;
            if (reg_we && reg_sel == 3) m_sop = int'(reg_wdata[2:0]);
            if (reg_we && reg_sel == 5) begin m_iee = reg_wdata[0]; m_ied = reg_wdata[1]; end
            if (reg_we && reg_sel == 0) begin m_pc = 0; m_div = int'(reg_wdata[7:0]); m_divset = 1; end
            else if (m_divset) m_pc = tk ? 0 : m_pc + 1;
        end
    end

    // per-clock comparison, away from the active edge
    int pw = 0, pw_last = 0, ew = 0, ew_last = 0, hv_falls = 0;
    bit prev_hv = 0;
    always @(negedge clk) begin
        if (armed && !finished) begin
            bit md;
            md = !m_fv && m_st == 0;
            chk(buf_empty == !m_fv, "R2", "buf_empty", 16'(buf_empty), 16'(!m_fv));
            chk(cmd_done == md, "R11", "cmd_done", 16'(cmd_done), 16'(md));
            chk(acc_err == m_err, "R4", "acc_err", 16'(acc_err), 16'(m_err));
            chk(hv_en == (m_st == 1 || m_st == 2), "R6", "hv_en", 16'(hv_en), 16'(m_st == 1 || m_st == 2));
            chk(pgm_strobe == (m_st == 2 && e_op == 1), "R5", "pgm_strobe", 16'(pgm_strobe), 16'(m_st == 2 && e_op == 1));
            chk(ers_strobe == (m_st == 2 && e_op == 2), "R7", "ers_strobe", 16'(ers_strobe), 16'(m_st == 2 && e_op == 2));
            chk(blank == m_blank, "R9", "blank", 16'(blank), 16'(m_blank));
            chk(result == m_result, "R10", "result", result, m_result);
            chk(irq_empty == (!m_fv && m_iee), "R12", "irq_empty", 16'(irq_empty), 16'(!m_fv && m_iee));
            chk(irq_done == (md && m_ied), "R12", "irq_done", 16'(irq_done), 16'(md && m_ied));
        end
        if (pgm_strobe) pw++; else if (pw != 0) begin pw_last = pw; pw = 0; end
        if (ers_strobe) ew++; else if (ew != 0) begin ew_last = ew; ew = 0; end
        if (prev_hv && !hv_en) hv_falls++;
        prev_hv = hv_en;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        reg_we = 1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic issue(input int op, input int addr, input logic [15:0] data);
        wr(3'd1, 16'(addr));
        wr(3'd2, data);
        wr(3'd3, 16'(op));
        wr(3'd4, 16'h0001);
    endtask

    task automatic wait_done();
        while (!cmd_done) @(negedge clk);
    endtask

    task automatic idle_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [15:0] fold_row(input logic [15:0] words [8]);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < 8; i++) c = {c[14:0], c[15]} ^ words[i];
        return c;
    endfunction

    initial begin
        logic [15:0] row0 [8];
        logic [15:0] cks_before;
        int f0;
        idle_n(3);
        rst = 0;
        armed = 1;
        @(negedge clk);
        // reset state
        chk(buf_empty && cmd_done && !acc_err && !hv_en, "R11", "reset flags",
            16'({buf_empty, cmd_done, acc_err, hv_en}), 16'b1100);

        // R1: launch before divider is written
        issue(3, 0, 16'h0);
        chk(acc_err == 1, "R1", "launch without divider", 16'(acc_err), 16'h1);
        chk(buf_empty == 1, "R1", "nothing queued", 16'(buf_empty), 16'h1);
        wr(3'd4, 16'h0002);
        chk(acc_err == 0, "R4", "error cleared", 16'(acc_err), 16'h0);

        wr(3'd0, 16'd3);     // period 4
        wr(3'd5, 16'h0003);  // both interrupt enables
        chk(irq_done == 1, "R12", "irq_done while idle", 16'(irq_done), 16'h1);

        // R5: single program, strobe width
        issue(1, 5, 16'h00F0);
        chk(buf_empty == 0 || !cmd_done, "R2", "command accepted", 16'(cmd_done), 16'h0);
        chk(irq_done == 0, "R12", "irq_done busy", 16'(irq_done), 16'h0);
        wait_done();
        idle_n(1);
        chk(pw_last == PROG * 4, "R5", "program strobe width", 16'(pw_last), 16'(PROG * 4));

        // R10: compress row 0
        issue(5, 0, 16'h0);
        wait_done();
        for (int i = 0; i < 8; i++) row0[i] = 16'hFFFF;
        row0[5] = 16'h00F0;
        chk(result == fold_row(row0), "R10", "compress row 0", result, fold_row(row0));
        cks_before = result;

        // R9: verify programmed row
        issue(3, 0, 16'h0);
        wait_done();
        chk(blank == 0, "R9", "verify dirty row", 16'(blank), 16'h0);

        // R6: same-row chain keeps hv
        f0 = hv_falls;
        issue(1, 8, 16'h1234);
        issue(1, 9, 16'h5678);
        wait_done();
        idle_n(1);
        chk(hv_falls - f0 == 1, "R6", "same-row hv falls", 16'(hv_falls - f0), 16'h1);
        // different rows drop hv
        f0 = hv_falls;
        issue(1, 10, 16'h0F0F);
        issue(1, 20, 16'hF0F0);
        wait_done();
        idle_n(1);
        chk(hv_falls - f0 == 2, "R6", "cross-row hv falls", 16'(hv_falls - f0), 16'h2);

        // R3: launch into occupied slot
        issue(1, 11, 16'h0001);
        issue(1, 12, 16'h0002);
        wr(3'd4, 16'h0001);
        chk(acc_err == 1, "R3", "launch while full", 16'(acc_err), 16'h1);
        wait_done();
        wr(3'd4, 16'h0002);

        // R4: illegal opcode, then blocked launch
        issue(6, 0, 16'h0);
        chk(acc_err == 1, "R4", "illegal opcode", 16'(acc_err), 16'h1);
        issue(1, 30, 16'h0000);
        idle_n(3);
        chk(buf_empty == 1 && hv_en == 0, "R4", "launch blocked by error",
            16'({buf_empty, hv_en}), 16'b10);
        wr(3'd4, 16'h0002);
        chk(acc_err == 0, "R4", "error cleared again", 16'(acc_err), 16'h0);

        // R7 and R9: erase row 1, verify blank
        issue(2, 8, 16'h0);
        wait_done();
        idle_n(1);
        chk(ew_last == ERASE * 4, "R7", "erase strobe width", 16'(ew_last), 16'(ERASE * 4));
        issue(3, 8, 16'h0);
        wait_done();
        chk(blank == 1, "R9", "verify erased row", 16'(blank), 16'h1);

        // R8: abort a running erase of row 0
        issue(2, 0, 16'h0);
        while (!ers_strobe) @(negedge clk);
        wr(3'd3, 16'd4);
        wr(3'd4, 16'h0001);
        idle_n(1);
        chk(hv_en == 0, "R8", "abort drops hv", 16'(hv_en), 16'h0);
        wait_done();
        issue(5, 0, 16'h0);
        wait_done();
        chk(result == cks_before, "R8", "row unchanged after abort", result, cks_before);
        // abort with nothing running
        issue(4, 0, 16'h0);
        idle_n(2);
        chk(cmd_done == 1 && hv_en == 0, "R8", "idle abort", 16'({cmd_done, hv_en}), 16'b10);

        // R1: divider 0 gives one tick per clock
        wr(3'd0, 16'd0);
        issue(2, 16, 16'h0);
        wait_done();
        idle_n(1);
        chk(ew_last == ERASE, "R1", "erase width at divider 0", 16'(ew_last), 16'(ERASE));

        // R12: only the empty interrupt enabled
        wr(3'd5, 16'h0001);
        idle_n(1);
        chk(irq_empty == 1 && irq_done == 0, "R12", "enable masking",
            16'({irq_empty, irq_done}), 16'b10);

        idle_n(2);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule